// File: doc/BRIEF.md
# Boot Image Loader

This block runs once after reset and decides how the processor starts. A boot-select pin is captured while reset is held. If the pin is low, the block reports at once that the processor may start from external memory. If the pin is high, the block probes up to three boot sources in a fixed priority order: the first serial dataflash, then the second serial dataflash, then NAND flash. Each source must hold a header of seven 32-bit words, which is 28 bytes. The block checks each source for an exception-vector signature.

The first source whose header passes supplies an image length in bytes. The block copies that many bytes, rounded up to whole words, from the start of the source into internal SRAM. It then raises a remap request so that SRAM appears at address zero. One cycle later it releases the processor. If no source passes, the block stops in a failure state and never requests remap.

Sources are reached through one word-read port. The port has a request handshake and a response handshake, and a select field names the source. SRAM is reached through a word-write port with its own handshake. The flash protocols and the processor sit outside the block.

Top module: `boot_image_loader`

## Requirements
- R1: `boot_sel_i` is sampled while `rst_n` is low. If the sample is 0, then at the first clock edge after reset release both `done_o` and `cpu_start_o` go to 1. In that case no source request and no SRAM write is ever made, and `remap_req_o` stays 0. While `rst_n` is low, all outputs are 0.
- R2: With the sample at 1, sources are probed in the order select 0 (first serial dataflash), select 1 (second serial dataflash), select 2 (NAND). Probing stops at the first source that passes. Each probe reads the seven words at byte addresses 0x00 to 0x18. Select value 3 is never issued.
- R3: The header words at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x18 must each be a vector word. A vector word has bits 31:24 equal to 0xEA, or bits 31:12 equal to 0xE59FF. One non-vector word rejects the source.
- R4: The word at byte offset 0x14 is exempt from the vector test. Its full 32-bit value is the image length in bytes. A length of 0, or a length larger than `SRAM_BYTES`, rejects the source. `SRAM_BYTES` must be a multiple of 4.
- R5: For the chosen source, ceil(length/4) words are read from byte addresses 0, 4, 8 and so on. Each word is written to SRAM word address 0, 1, 2 and so on. No other SRAM word is written.
- R6: `remap_req_o` rises only after the last SRAM write has been accepted, and then stays high until reset. `cpu_start_o` rises exactly one cycle after `remap_req_o` and stays high. `done_o` follows.
- R7: If all three sources are rejected, `fail_o` goes high and stays high. In that case `remap_req_o`, `cpu_start_o` and `done_o` stay 0, and no SRAM write is made.
- R8: A read request holds its select and address stable until it is accepted. At most one read is outstanding, and `src_rsp_ready_o` is high only while a response is awaited. An SRAM write holds its address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel_i | input | 1 | Boot-select pin, captured during reset |
| src_req_valid_o | output | 1 | Read request valid |
| src_req_ready_i | input | 1 | Read request accepted |
| src_req_sel_o | output | 2 | Source select (0, 1 dataflash; 2 NAND) |
| src_req_addr_o | output | AW | Byte address, word aligned |
| src_rsp_valid_i | input | 1 | Read data valid |
| src_rsp_ready_o | output | 1 | Block awaits read data |
| src_rsp_data_i | input | 32 | Read data word |
| sram_wr_valid_o | output | 1 | SRAM write valid |
| sram_wr_ready_i | input | 1 | SRAM write accepted |
| sram_wr_addr_o | output | WAW | SRAM word address |
| sram_wr_data_o | output | 32 | SRAM write data |
| remap_req_o | output | 1 | Request SRAM at address zero |
| cpu_start_o | output | 1 | Release processor |
| done_o | output | 1 | Sequence finished with a start |
| fail_o | output | 1 | No bootable source found |

## Verification
With the pin low, `done_o` and `cpu_start_o` are due on the first edge after reset release. The bench checks them at the falling edge that follows, and again after a quiet period for absent requests. With the pin high, the finish time depends on handshake stalls and response latency. The bench therefore waits, at falling edges, for `done_o` or `fail_o`, and then checks the SRAM image, the per-source request counts and the probe order that its models recorded. The one-cycle gap between remap and start is measured from cycle stamps taken at rising edges, and this is compared exactly.

// File: rtl/bil_pkg.sv
// Shared types and helpers for the boot image loader.
// Assumes a 32-bit source word and a seven-word boot header.
package bil_pkg;

    localparam int HDR_WORDS = 7;
    localparam logic [2:0] LEN_SLOT  = 3'd5;
    localparam logic [2:0] LAST_HDR  = 3'd6;
    localparam logic [1:0] LAST_SRC  = 2'd2;

    typedef enum logic [3:0] {
        S_START,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_EVAL,
        S_NEXT,
        S_CP_REQ,
        S_CP_WAIT,
        S_CP_WR,
        S_GO,
        S_DONE,
        S_FAIL
    } seq_state_e;

    // True when a word is a branch or a PC-relative load to the program counter
    function automatic logic is_vector(input logic [31:0] w);
        return (w[31:24] == 8'hEA) || (w[31:12] == 20'hE59FF);
    endfunction

endpackage

// File: rtl/bil_reader.sv
// Single-outstanding word reader.
// It takes a one-cycle go pulse with a select and an address. It then
// holds the request until accepted, waits for one response, and returns
// the word with a one-cycle done pulse. Assumes go is only pulsed while idle.
module bil_reader #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [1:0]    go_sel,
    input  logic [AW-1:0] go_addr,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [1:0]    req_sel,
    output logic [AW-1:0] req_addr,
    input  logic          rsp_valid,
    output logic          rsp_ready,
    input  logic [31:0]   rsp_data,
    output logic [31:0]   word,
    output logic          done
);
    typedef enum logic [1:0] {R_IDLE, R_REQ, R_WAIT} rd_phase_e;
    rd_phase_e phase;

    // Phase sequencing, request capture and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= R_IDLE;
            req_sel  <= '0;
            req_addr <= '0;
            word     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                R_IDLE: if (go) begin
                    req_sel  <= go_sel;
                    req_addr <= go_addr;
                    phase    <= R_REQ;
                end
                R_REQ: if (req_ready) phase <= R_WAIT;
                R_WAIT: if (rsp_valid) begin
                    word  <= rsp_data;
                    done  <= 1'b1;
                    phase <= R_IDLE;
                end
                default: phase <= R_IDLE;
            endcase
        end
    end

    // Handshake outputs follow the phase
    always_comb begin
        req_valid = (phase == R_REQ);
        rsp_ready = (phase == R_WAIT);
    end
endmodule

// File: rtl/bil_hdr_check.sv
// Header validator.
// It accumulates vector-word checks over the seven header words and keeps
// the length slot. It reports pass or fail and the word count to copy.
// Assumes clear is pulsed before each new header, and SRAM_BYTES is a multiple of 4.
module bil_hdr_check #(
    parameter int SRAM_BYTES = 4096,
    localparam int SW  = SRAM_BYTES / 4,
    localparam int WAW = $clog2(SW)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         we,
    input  logic [2:0]   idx,
    input  logic [31:0]  data,
    output logic         ok,
    output logic [WAW:0] nwords
);
    import bil_pkg::*;

    logic        bad_q;
    logic [31:0] len_q;
    logic [32:0] words;

    // Record the length slot and note any non-vector word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bad_q <= 1'b0;
            len_q <= '0;
        end else if (we) begin
            if (idx == LEN_SLOT)
                len_q <= data;
            else if (!is_vector(data))
                bad_q <= 1'b1;
        end
    end

    // Round the byte length up to words and range-check it against SRAM
    always_comb begin
        words  = ({1'b0, len_q} + 33'd3) >> 2;
        ok     = !bad_q && (len_q != 32'd0) && (words <= 33'(SW));
        nwords = words[WAW:0];
    end
endmodule

// File: rtl/bil_writer.sv
// One-entry SRAM write buffer.
// A go pulse loads address and data. Valid is then held until ready.
// Assumes go is only pulsed while the buffer is empty.
module bil_writer #(
    parameter int WAW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [WAW-1:0] go_addr,
    input  logic [31:0]    go_data,
    output logic           wr_valid,
    input  logic           wr_ready,
    output logic [WAW-1:0] wr_addr,
    output logic [31:0]    wr_data
);
    // Load on go, release on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (go) begin
            wr_valid <= 1'b1;
            wr_addr  <= go_addr;
            wr_data  <= go_data;
        end else if (wr_valid && wr_ready) begin
            wr_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_image_loader.sv
// Boot image loader top.
// It captures the boot pin during reset. With the pin high it probes three
// sources in priority order for a vector header, copies the chosen image
// into SRAM, requests remap, and one cycle later starts the processor.
// Assumes AW >= WAW + 2 and SRAM_BYTES is a multiple of 4.
module boot_image_loader #(
    parameter int AW         = 24,
    parameter int SRAM_BYTES = 4096,
    localparam int WAW       = $clog2(SRAM_BYTES / 4)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           boot_sel_i,
    output logic           src_req_valid_o,
    input  logic           src_req_ready_i,
    output logic [1:0]     src_req_sel_o,
    output logic [AW-1:0]  src_req_addr_o,
    input  logic           src_rsp_valid_i,
    output logic           src_rsp_ready_o,
    input  logic [31:0]    src_rsp_data_i,
    output logic           sram_wr_valid_o,
    input  logic           sram_wr_ready_i,
    output logic [WAW-1:0] sram_wr_addr_o,
    output logic [31:0]    sram_wr_data_o,
    output logic           remap_req_o,
    output logic           cpu_start_o,
    output logic           done_o,
    output logic           fail_o
);
    import bil_pkg::*;

    seq_state_e     state;
    logic           pin_q;
    logic [1:0]     src_q;
    logic [2:0]     widx;
    logic [WAW-1:0] cw;
    logic [WAW:0]   nwords_q;
    logic           remap_q, start_q, fail_q;

    logic           rd_go, rd_done;
    logic [AW-1:0]  rd_addr;
    logic [31:0]    rd_word;
    logic           hdr_clr, hdr_we, hdr_ok;
    logic [WAW:0]   hdr_nwords;
    logic           wr_go;
    logic           last_word;

    bil_reader #(.AW(AW)) u_reader (
        .clk(clk), .rst_n(rst_n),
        .go(rd_go), .go_sel(src_q), .go_addr(rd_addr),
        .req_valid(src_req_valid_o), .req_ready(src_req_ready_i),
        .req_sel(src_req_sel_o), .req_addr(src_req_addr_o),
        .rsp_valid(src_rsp_valid_i), .rsp_ready(src_rsp_ready_o),
        .rsp_data(src_rsp_data_i),
        .word(rd_word), .done(rd_done)
    );

    bil_hdr_check #(.SRAM_BYTES(SRAM_BYTES)) u_hdr (
        .clk(clk), .rst_n(rst_n),
        .clear(hdr_clr), .we(hdr_we), .idx(widx), .data(rd_word),
        .ok(hdr_ok), .nwords(hdr_nwords)
    );

    bil_writer #(.WAW(WAW)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .go(wr_go), .go_addr(cw), .go_data(rd_word),
        .wr_valid(sram_wr_valid_o), .wr_ready(sram_wr_ready_i),
        .wr_addr(sram_wr_addr_o), .wr_data(sram_wr_data_o)
    );

    // Per-state strobes toward the reader, checker and writer
    always_comb begin
        rd_go     = (state == S_HDR_REQ) || (state == S_CP_REQ);
        rd_addr   = (state == S_CP_REQ) ? AW'({cw, 2'b00}) : AW'({widx, 2'b00});
        hdr_clr   = (state == S_START) || (state == S_NEXT);
        hdr_we    = rd_done && (state == S_HDR_WAIT);
        wr_go     = rd_done && (state == S_CP_WAIT);
        last_word = (({1'b0, cw} + (WAW+1)'(1)) == nwords_q);
    end

    // Main sequencer: probe, evaluate, copy, remap, start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_START;
            pin_q    <= boot_sel_i;
            src_q    <= '0;
            widx     <= '0;
            cw       <= '0;
            nwords_q <= '0;
            remap_q  <= 1'b0;
            start_q  <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            case (state)
                S_START: begin
                    if (pin_q) begin
                        state <= S_HDR_REQ;
                    end else begin
                        start_q <= 1'b1;
                        state   <= S_DONE;
                    end
                end
                S_HDR_REQ: state <= S_HDR_WAIT;
                S_HDR_WAIT: if (rd_done) begin
                    if (widx == LAST_HDR) begin
                        state <= S_EVAL;
                    end else begin
                        widx  <= widx + 3'd1;
                        state <= S_HDR_REQ;
                    end
                end
                S_EVAL: begin
                    if (hdr_ok) begin
                        nwords_q <= hdr_nwords;
                        cw       <= '0;
                        state    <= S_CP_REQ;
                    end else begin
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (src_q == LAST_SRC) begin
                        fail_q <= 1'b1;
                        state  <= S_FAIL;
                    end else begin
                        src_q <= src_q + 2'd1;
                        widx  <= '0;
                        state <= S_HDR_REQ;
                    end
                end
                S_CP_REQ: state <= S_CP_WAIT;
                S_CP_WAIT: if (rd_done) state <= S_CP_WR;
                S_CP_WR: if (!sram_wr_valid_o) begin
                    if (last_word) begin
                        remap_q <= 1'b1;
                        state   <= S_GO;
                    end else begin
                        cw    <= cw + 1'b1;
                        state <= S_CP_REQ;
                    end
                end
                S_GO: begin
                    start_q <= 1'b1;
                    state   <= S_DONE;
                end
                S_DONE: state <= S_DONE;
                S_FAIL: state <= S_FAIL;
                default: state <= S_FAIL;
            endcase
        end
    end

    // Status outputs come from registers and state
    always_comb begin
        remap_req_o = remap_q;
        cpu_start_o = start_q;
        fail_o      = fail_q;
        done_o      = (state == S_DONE);
    end
endmodule

// File: rtl/bil_checker.sv
// Protocol and sequencing properties for the boot image loader, bound to the top.
module bil_checker #(
    parameter int AW  = 24,
    parameter int WAW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [1:0]     req_sel,
    input logic [AW-1:0]  req_addr,
    input logic           rsp_ready,
    input logic           wr_valid,
    input logic           wr_ready,
    input logic [WAW-1:0] wr_addr,
    input logic [31:0]    wr_data,
    input logic           remap,
    input logic           start,
    input logic           done,
    input logic           fail
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_sel));

    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> !req_valid);

    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_sel != 2'd3);

    a_r6_remap_held: assert property (@(posedge clk) disable iff (!rst_n)
        remap |=> remap);

    a_r6_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remap) |=> $rose(start));

    a_r6_no_write_after_remap: assert property (@(posedge clk) disable iff (!rst_n)
        remap |-> !wr_valid && !req_valid);

    a_r7_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !remap && !start && !wr_valid && !done);
endmodule

bind boot_image_loader bil_checker #(.AW(AW), .WAW($clog2(SRAM_BYTES / 4))) u_bil_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(src_req_valid_o), .req_ready(src_req_ready_i),
    .req_sel(src_req_sel_o), .req_addr(src_req_addr_o),
    .rsp_ready(src_rsp_ready_o),
    .wr_valid(sram_wr_valid_o), .wr_ready(sram_wr_ready_i),
    .wr_addr(sram_wr_addr_o), .wr_data(sram_wr_data_o),
    .remap(remap_req_o), .start(cpu_start_o), .done(done_o), .fail(fail_o)
);

// File: tb/boot_image_loader_bench.sv
module boot_image_loader_bench;
    localparam int AW  = 24;
    localparam int SB  = 128;
    localparam int SW  = SB / 4;
    localparam int WAW = $clog2(SW);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           boot_sel = 1'b0;
    logic           req_valid, req_ready;
    logic [1:0]     req_sel;
    logic [AW-1:0]  req_addr;
    logic           rsp_valid, rsp_ready;
    logic [31:0]    rsp_data;
    logic           wr_valid, wr_ready;
    logic [WAW-1:0] wr_addr;
    logic [31:0]    wr_data;
    logic           remap, start, done, fail;

    boot_image_loader #(.AW(AW), .SRAM_BYTES(SB)) u_boot_image_loader (
        .clk(clk), .rst_n(rst_n), .boot_sel_i(boot_sel),
        .src_req_valid_o(req_valid), .src_req_ready_i(req_ready),
        .src_req_sel_o(req_sel), .src_req_addr_o(req_addr),
        .src_rsp_valid_i(rsp_valid), .src_rsp_ready_o(rsp_ready),
        .src_rsp_data_i(rsp_data),
        .sram_wr_valid_o(wr_valid), .sram_wr_ready_i(wr_ready),
        .sram_wr_addr_o(wr_addr), .sram_wr_data_o(wr_data),
        .remap_req_o(remap), .cpu_start_o(start), .done_o(done), .fail_o(fail)
    );

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;

    // Source configuration: length slot, index of a corrupted word (-1 none), its value
    int          cfg_len[3];
    int          cfg_bad[3];
    logic [31:0] cfg_badval[3];

    function automatic logic [31:0] img(int s, int w);
        if (w == 5) return 32'(cfg_len[s]);
        if (w < 7) begin
            if (w == cfg_bad[s]) return cfg_badval[s];
            if (s == 2) return 32'hE59FF000 | 32'(s << 8) | 32'(w);
            return 32'hEA000000 | 32'(s << 8) | 32'(w);
        end
        return 32'hA0000000 + 32'(s * 32'h0100_0000) + 32'(w);
    endfunction

    // Stall patterns on the two accepting handshakes
    assign req_ready = (cyc % 4) != 3;
    assign wr_ready  = (cyc % 3) != 1;

    // Source and SRAM models with request logging
    int          pend, dly, p_sel, p_addr;
    int          nreq[3];
    int          order[4];
    int          norder, last_sel, overlap_err, nwr;
    int          remap_cyc, start_cyc, wr_at_remap;
    logic        remap_seen, start_seen;
    logic [31:0] sram[64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            pend <= 0; dly <= 0; p_sel <= 0; p_addr <= 0;
            rsp_valid <= 1'b0; rsp_data <= '0;
            for (int i = 0; i < 3; i++) nreq[i] <= 0;
            for (int i = 0; i < 4; i++) order[i] <= -1;
            norder <= 0; last_sel <= -1; overlap_err <= 0; nwr <= 0;
            remap_seen <= 1'b0; start_seen <= 1'b0;
            remap_cyc <= 0; start_cyc <= 0; wr_at_remap <= 0;
            for (int i = 0; i < 64; i++) sram[i] <= 32'hDEADBEEF;
        end else begin
            if (req_valid && req_ready) begin
                if (pend != 0 || rsp_valid) overlap_err <= overlap_err + 1;
                pend   <= 1;
                dly    <= 2;
                p_sel  <= int'(req_sel);
                p_addr <= int'(req_addr);
                if (req_sel != 2'd3) nreq[req_sel] <= nreq[req_sel] + 1;
                else overlap_err <= overlap_err + 1;
                if (int'(req_sel) != last_sel) begin
                    if (norder < 4) order[norder] <= int'(req_sel);
                    norder   <= norder + 1;
                    last_sel <= int'(req_sel);
                end
            end else if (pend != 0) begin
                if (dly <= 1) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= img(p_sel, p_addr / 4);
                    pend      <= 0;
                end else begin
                    dly <= dly - 1;
                end
            end
            if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
            if (wr_valid && wr_ready) begin
                sram[wr_addr] <= wr_data;
                nwr <= nwr + 1;
            end
            if (remap && !remap_seen) begin
                remap_seen  <= 1'b1;
                remap_cyc   <= cyc;
                wr_at_remap <= nwr;
            end
            if (start && !start_seen) begin
                start_seen <= 1'b1;
                start_cyc  <= cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_src(input int s, input int len, input int bad, input logic [31:0] badval);
        cfg_len[s]    = len;
        cfg_bad[s]    = bad;
        cfg_badval[s] = badval;
    endtask

    function automatic bit src_ok(int s);
        return cfg_bad[s] < 0 && cfg_len[s] > 0 && cfg_len[s] <= SB;
    endfunction

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n    = 1'b0;
        boot_sel = pin;
        repeat (3) @(negedge clk);
        check(!remap && !start && !done && !fail && !req_valid && !wr_valid,
              "R1", "outputs low in reset", int'({remap, start, done, fail}), 0);
        rst_n = 1'b1;
    endtask

    // Pin low: immediate start, no probing, no remap
    task automatic run_external();
        set_src(0, 16, -1, 0);
        set_src(1, 16, -1, 0);
        set_src(2, 16, -1, 0);
        do_reset(1'b0);
        @(posedge clk);
        @(negedge clk);
        check(done && start, "R1", "done and start one edge after release",
              int'({done, start}), 3);
        repeat (20) @(negedge clk);
        check(nreq[0] + nreq[1] + nreq[2] == 0, "R1", "no source requests",
              nreq[0] + nreq[1] + nreq[2], 0);
        check(nwr == 0 && !remap, "R1", "no SRAM write and no remap", nwr, 0);
    endtask

    // Pin high: probe, pick, copy, or fail; compare against the expected choice
    task automatic run_internal(input string tag);
        int c = -1;
        int n = 0;
        int bad = 0;
        int waited = 0;
        for (int s = 2; s >= 0; s--) if (src_ok(s)) c = s;
        if (c >= 0) n = (cfg_len[c] + 3) / 4;
        do_reset(1'b1);
        while (!done && !fail && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 5000, tag, "sequence finished", waited, 5000);
        repeat (3) @(negedge clk);
        check(overlap_err == 0, "R8", "single outstanding read", overlap_err, 0);
        if (c >= 0) begin
            check(done && !fail, "R2", "done without fail", int'({done, fail}), 2);
            check(norder == c + 1, "R2", "sources probed", norder, c + 1);
            for (int s = 0; s <= c; s++)
                check(order[s] == s, "R2", "probe order", order[s], s);
            for (int s = 0; s < 3; s++)
                check(nreq[s] == ((s < c) ? 7 : (s == c) ? 7 + n : 0), tag,
                      "requests per source", nreq[s], (s < c) ? 7 : (s == c) ? 7 + n : 0);
            check(nwr == n, "R5", "SRAM words written", nwr, n);
            for (int i = 0; i < n; i++) if (sram[i] !== img(c, i)) bad++;
            check(bad == 0, "R5", "SRAM image mismatches", bad, 0);
            check(sram[n] === 32'hDEADBEEF, "R5", "word past image untouched",
                  int'(sram[n]), int'(32'hDEADBEEF));
            check(remap && start, "R6", "remap and start held", int'({remap, start}), 3);
            check(wr_at_remap == n, "R6", "writes done before remap", wr_at_remap, n);
            check(start_cyc - remap_cyc == 1, "R6", "start one cycle after remap",
                  start_cyc - remap_cyc, 1);
        end else begin
            check(fail && !done, "R7", "fail without done", int'({fail, done}), 2);
            check(!remap && !start, "R7", "no remap, no start", int'({remap, start}), 0);
            check(nwr == 0, "R7", "no SRAM writes", nwr, 0);
            check(norder == 3, "R2", "all three probed", norder, 3);
            for (int s = 0; s < 3; s++)
                check(nreq[s] == 7, tag, "header reads only", nreq[s], 7);
        end
    endtask

    // Scenario: first dataflash valid, word-aligned length
    task automatic t_first_source();
        set_src(0, 20, -1, 0);
        set_src(1, 40, -1, 0);
        set_src(2, 40, -1, 0);
        run_internal("R2");
    endtask

    // Scenario: first rejected by a non-vector word, second chosen with ragged length
    task automatic t_bad_vector();
        set_src(0, 20, 2, 32'hEB000000);
        set_src(1, 13, -1, 0);
        set_src(2, 40, -1, 0);
        run_internal("R3");
    endtask

    // Scenario: zero and oversize lengths rejected, NAND chosen at full SRAM size
    task automatic t_length_limits();
        set_src(0, 0, -1, 0);
        set_src(1, SB + 4, -1, 0);
        set_src(2, SB, -1, 0);
        run_internal("R4");
    endtask

    // Scenario: NAND chosen with a one-byte image, near-miss load word rejected earlier
    task automatic t_one_byte();
        set_src(0, 20, 6, 32'hE59FE000);
        set_src(1, 20, 4, 32'h00000000);
        set_src(2, 1, -1, 0);
        run_internal("R3");
    endtask

    // Scenario: every source rejected
    task automatic t_all_fail();
        set_src(0, 20, 0, 32'hE9000000);
        set_src(1, SB + 1, -1, 0);
        set_src(2, 0, -1, 0);
        run_internal("R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        run_external();
        t_first_source();
        t_bad_vector();
        t_length_limits();
        t_one_byte();
        t_all_fail();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule